// File: doc/BRIEF.md
# Lockable Cache Way Allocation Selector

This block picks the victim way for line fills in a 4-way set-associative cache. It also holds the cache's main control bits. The data and tag arrays, the bus side and the write-back path sit outside it.

Ordinary misses and prefetch misses both ask for a way. The caller supplies the LRU state of the addressed set. One cycle later the block answers with a fill strobe, the chosen way and the line-aligned fill address.

While the processor runs in its signal-processing mode, a lock register can reserve way 2, way 3 or both. Prefetch misses then fill the reserved way instead of the LRU way. Ordinary misses in that mode never evict a reserved way. Outside that mode the lock register has no effect.

A write to the control register can request a flush. The block answers with a one-cycle pulse that clears the valid, updated and LRU bits of every entry, with no write-back.

Top module: `way_alloc_sel`

## Requirements
- R1: After reset, `fill_en`, `flush_clr`, `cache_en`, `wt_mode`, `wb_kernel` and `ctl_rdata` are 0, and both lock fields are 00.
- R2: `lru_bits` hold one bit per way pair, ordered (0,1),(0,2),(0,3),(1,2),(1,3),(2,3). A 1 means the lower-numbered way of the pair was used more recently. With `dsp_mode` low, a prefetch miss fills the least recently used of all four ways, whatever the lock fields hold.
- R3: With `dsp_mode` high and the way-3 field (lock write bits 9:8) equal to 11, a prefetch miss fills way 3.
- R4: With `dsp_mode` high, the way-2 field (lock write bits 1:0) equal to 11 and the way-3 field not 11, a prefetch miss fills way 2.
- R5: With `dsp_mode` high and both fields equal to 11, a prefetch miss fills way 3.
- R6: With `dsp_mode` high, field values 00, 01 and 10 give no lock, and the prefetch miss fills the LRU way.
- R7: A prefetch with `pf_hit` high produces no fill (`fill_en` stays 0).
- R8: An ordinary miss (`miss_req`) fills the least recently used way among the ways not locked. A way counts as locked only when `dsp_mode` is high and its field is 11.
- R9: Each fill request raises `fill_en` for exactly the next cycle. In that cycle `fill_addr` is `req_addr` with its low log2(LINE_BYTES) bits cleared.
- R10: A control write stores `wr_data` bit 0 as cache enable, bit 1 as write-through and bit 2 as kernel write-back. `ctl_rdata` returns these in bits 0 to 2 and returns 0 in bit 3 and in all reserved bits.
- R11: A control write with `wr_data` bit 3 set gives a one-cycle `flush_clr` pulse in the next cycle.
- R12: A lock register write is ignored while `cache_en` is 1.
- R13: When `miss_req` and `pf_req` are both high, the ordinary miss is served and the prefetch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_mode | input | 1 | Processor signal-processing mode flag |
| ctl_we | input | 1 | Control register write strobe |
| lk_we | input | 1 | Lock register write strobe |
| wr_data | input | 32 | Register write data |
| ctl_rdata | output | 32 | Control register read value |
| cache_en | output | 1 | Cache enable |
| wt_mode | output | 1 | Write-through for general areas |
| wb_kernel | output | 1 | Write-back for kernel area |
| pf_req | input | 1 | Prefetch request |
| pf_hit | input | 1 | Prefetch hit indication |
| miss_req | input | 1 | Ordinary miss request |
| req_addr | input | AW | Request address |
| lru_bits | input | 6 | Pairwise LRU state of the addressed set |
| fill_en | output | 1 | Fill strobe |
| fill_way | output | 2 | Way to fill |
| fill_addr | output | AW | Line-aligned fill address |
| flush_clr | output | 1 | Clear valid, updated and LRU bits of all entries |

## Verification
A request seen at a clock edge yields `fill_en`, `fill_way` and `fill_addr` in the cycle that follows. `flush_clr` follows its control write by one cycle. A register write shows on `ctl_rdata` and on the mode outputs in that same next cycle, while a lock write only changes the way chosen for the next request.

The bench reference model steps once per rising edge and applies exactly these latencies. The design's outputs are compared with it at every falling edge. The LRU input is always built from a true recency permutation, so the model picks the victim by rank rather than by decoding pair bits.

// File: rtl/way_alloc_sel.sv
module way_alloc_sel #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dsp_mode,
  input  logic          ctl_we,
  input  logic          lk_we,
  input  logic [31:0]   wr_data,
  output logic [31:0]   ctl_rdata,
  output logic          cache_en,
  output logic          wt_mode,
  output logic          wb_kernel,
  input  logic          pf_req,
  input  logic          pf_hit,
  input  logic          miss_req,
  input  logic [AW-1:0] req_addr,
  input  logic [5:0]    lru_bits,
  output logic          fill_en,
  output logic [1:0]    fill_way,
  output logic [AW-1:0] fill_addr,
  output logic          flush_clr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [1:0] lk2_q, lk3_q;
  logic       ce_q, wt_q, wb_q, flush_q, en_q;
  logic [1:0] way_q;
  logic [AW-1:0] addr_q;
  logic [3:0] req_mask;
  logic [1:0] victim, nxt_way;
  logic       lock2, lock3, pf_fill;
  logic       unused_bits;

  assign unused_bits = ^{wr_data[31:10], wr_data[7:4]};

  function automatic logic newer(input logic [5:0] l, input logic [1:0] a, input logic [1:0] b);
    case ({a, b})
      4'b0001: newer = l[0];
      4'b0100: newer = ~l[0];
      4'b0010: newer = l[1];
      4'b1000: newer = ~l[1];
      4'b0011: newer = l[2];
      4'b1100: newer = ~l[2];
      4'b0110: newer = l[3];
      4'b1001: newer = ~l[3];
      4'b0111: newer = l[4];
      4'b1101: newer = ~l[4];
      4'b1011: newer = l[5];
      4'b1110: newer = ~l[5];
      default: newer = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] oldest(input logic [5:0] l, input logic [3:0] m);
    logic found, ok;
    oldest = 2'd0;
    found  = 1'b0;
    for (int w = 0; w < 4; w++) begin
      ok = m[w] && !found;
      for (int v = 0; v < 4; v++)
        if (v != w && m[v] && newer(l, 2'(w), 2'(v))) ok = 1'b0;
      if (ok) begin
        oldest = 2'(w);
        found  = 1'b1;
      end
    end
  endfunction

  assign lock3    = dsp_mode && (lk3_q == 2'b11);
  assign lock2    = dsp_mode && (lk2_q == 2'b11);
  assign req_mask = miss_req ? ~{lock3, lock2, 2'b00} : 4'hf;
  assign victim   = oldest(lru_bits, req_mask);
  assign pf_fill  = pf_req && !pf_hit && !miss_req;
  assign nxt_way  = miss_req ? victim : lock3 ? 2'd3 : lock2 ? 2'd2 : victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk2_q   <= 2'b00;
      lk3_q   <= 2'b00;
      ce_q    <= 1'b0;
      wt_q    <= 1'b0;
      wb_q    <= 1'b0;
      flush_q <= 1'b0;
      en_q    <= 1'b0;
      way_q   <= 2'd0;
      addr_q  <= '0;
    end else begin
      en_q    <= miss_req || pf_fill;
      flush_q <= ctl_we && wr_data[3];
      if (miss_req || pf_fill) begin
        way_q  <= nxt_way;
        addr_q <= {req_addr[AW-1:OFF_W], OFF_W'(0)};
      end
      if (ctl_we) {wb_q, wt_q, ce_q} <= wr_data[2:0];
      if (lk_we && !ce_q) begin
        lk2_q <= wr_data[1:0];
        lk3_q <= wr_data[9:8];
      end
    end
  end

  assign ctl_rdata = {29'd0, wb_q, wt_q, ce_q};
  assign cache_en  = ce_q;
  assign wt_mode   = wt_q;
  assign wb_kernel = wb_q;
  assign fill_en   = en_q;
  assign fill_way  = way_q;
  assign fill_addr = addr_q;
  assign flush_clr = flush_q;

  a_r3_way3_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req && !pf_hit && !miss_req && dsp_mode && lk3_q == 2'b11 |=> fill_en && fill_way == 2'd3);
  a_r7_hit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req && pf_hit && !miss_req |=> !fill_en);
  a_r8_locked_spared: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && dsp_mode && lk3_q == 2'b11 |=> fill_en && fill_way != 2'd3);
  a_r9_idle_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req && !pf_req |=> !fill_en);
  a_r11_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wr_data[3] |=> flush_clr);
  a_r12_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lk_we && cache_en |=> $stable(lk3_q) && $stable(lk2_q));
endmodule

// File: tb/test_way_alloc_sel.sv
module test_way_alloc_sel;
  localparam int AW = 32;
  localparam int LINE_BYTES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsp_mode = 1'b0, ctl_we = 1'b0, lk_we = 1'b0;
  logic [31:0] wr_data = '0;
  logic pf_req = 1'b0, pf_hit = 1'b0, miss_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [5:0] lru_bits = '0;
  logic [31:0] ctl_rdata;
  logic cache_en, wt_mode, wb_kernel, fill_en, flush_clr;
  logic [1:0] fill_way;
  logic [AW-1:0] fill_addr;

  int checks = 0, fails = 0, cycles = 0;
  int rk[4] = '{0, 1, 2, 3};
  string cur_req = "R1", m_lbl = "R1";
  bit done = 0;

  bit m_en = 0, m_flush = 0, m_ce = 0, m_wt = 0, m_wb = 0, m_rst = 1;
  int m_way = 0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0] m_l2 = 0, m_l3 = 0;

  always #10 clk = ~clk;

  way_alloc_sel #(.AW(AW), .LINE_BYTES(LINE_BYTES)) i_way_alloc_sel (
    .clk(clk), .rst_n(rst_n), .dsp_mode(dsp_mode), .ctl_we(ctl_we), .lk_we(lk_we),
    .wr_data(wr_data), .ctl_rdata(ctl_rdata), .cache_en(cache_en), .wt_mode(wt_mode),
    .wb_kernel(wb_kernel), .pf_req(pf_req), .pf_hit(pf_hit), .miss_req(miss_req),
    .req_addr(req_addr), .lru_bits(lru_bits), .fill_en(fill_en), .fill_way(fill_way),
    .fill_addr(fill_addr), .flush_clr(flush_clr));

  function automatic int pick(input bit [3:0] m);
    int best = -1;
    for (int w = 0; w < 4; w++)
      if (m[w] && (best < 0 || rk[w] < rk[best])) best = w;
    return best;
  endfunction

  always @(posedge clk) begin
    bit l2, l3;
    m_lbl = cur_req;
    if (!rst_n) begin
      m_en = 0; m_flush = 0; m_ce = 0; m_wt = 0; m_wb = 0; m_l2 = 0; m_l3 = 0; m_rst = 1;
    end else begin
      m_rst = 0;
      l3 = dsp_mode && m_l3 == 2'b11;
      l2 = dsp_mode && m_l2 == 2'b11;
      m_en = 0;
      if (miss_req) begin
        m_en = 1;
        m_way = pick(4'hf & ~{l3, l2, 2'b00});
      end else if (pf_req && !pf_hit) begin
        m_en = 1;
        m_way = l3 ? 3 : l2 ? 2 : pick(4'hf);
      end
      if (m_en) m_addr = req_addr & ~AW'(LINE_BYTES - 1);
      m_flush = ctl_we && wr_data[3];
      if (lk_we && !m_ce) begin
        m_l2 = wr_data[1:0];
        m_l3 = wr_data[9:8];
      end
      if (ctl_we) begin
        m_ce = wr_data[0]; m_wt = wr_data[1]; m_wb = wr_data[2];
      end
    end
  end

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string fl = m_rst ? "R1" : m_lbl;
      string rc = m_rst ? "R1" : "R10";
      chk(fl, "fill_en", fill_en, m_en);
      if (m_en) begin
        chk(fl, "fill_way", fill_way, m_way);
        chk(m_rst ? "R1" : "R9", "fill_addr", fill_addr, m_addr);
      end
      chk(m_rst ? "R1" : "R11", "flush_clr", flush_clr, m_flush);
      chk(rc, "ctl_rdata", ctl_rdata, {29'd0, m_wb, m_wt, m_ce});
      chk(rc, "modes", {cache_en, wt_mode, wb_kernel}, {m_ce, m_wt, m_wb});
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  task automatic shuffle();
    for (int i = 3; i > 0; i--) begin
      int j = int'($urandom_range(i, 0));
      int t = rk[i];
      rk[i] = rk[j];
      rk[j] = t;
    end
    lru_bits = {rk[2] > rk[3], rk[1] > rk[3], rk[1] > rk[2],
                rk[0] > rk[3], rk[0] > rk[2], rk[0] > rk[1]};
  endtask

  task automatic idle();
    ctl_we = 0; lk_we = 0; pf_req = 0; pf_hit = 0; miss_req = 0;
  endtask

  task automatic wr(input string r, input bit is_lock, input logic [31:0] d);
    @(negedge clk);
    idle();
    cur_req = r;
    wr_data = d;
    if (is_lock) lk_we = 1; else ctl_we = 1;
  endtask

  task automatic op(input string r, input bit d, input bit pf, input bit hit, input bit ms);
    @(negedge clk);
    idle();
    cur_req = r;
    dsp_mode = d; pf_req = pf; pf_hit = hit; miss_req = ms;
    req_addr = $urandom;
    shuffle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    wr("R10", 0, 32'h0);
    wr("R2", 1, 32'h303);
    for (int i = 0; i < 6; i++) op("R2", 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) op("R5", 1, 1, 0, 0);
    wr("R3", 1, 32'h300);
    for (int i = 0; i < 4; i++) op("R3", 1, 1, 0, 0);
    wr("R4", 1, 32'h003);
    for (int i = 0; i < 4; i++) op("R4", 1, 1, 0, 0);
    for (int c = 0; c < 3; c++) begin
      wr("R6", 1, (32'(c) << 8) | 32'(c));
      for (int i = 0; i < 4; i++) op("R6", 1, 1, 0, 0);
    end
    wr("R7", 1, 32'h303);
    op("R7", 1, 1, 1, 0);
    op("R7", 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) op("R8", 1, 0, 0, 1);
    for (int i = 0; i < 3; i++) op("R8", 0, 0, 0, 1);
    wr("R8", 1, 32'h300);
    for (int i = 0; i < 4; i++) op("R8", 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) op("R13", 1, 1, 0, 1);
    wr("R10", 0, 32'h7);
    wr("R10", 0, 32'h5);
    wr("R11", 0, 32'hFFFF_FFF8);
    wr("R11", 0, 32'h0);
    wr("R12", 0, 32'h1);
    wr("R12", 1, 32'h000);
    op("R12", 1, 1, 0, 0);
    wr("R12", 0, 32'h0);
    wr("R12", 1, 32'h000);
    op("R12", 1, 1, 0, 0);
    for (int i = 0; i < 300; i++) begin
      int k = int'($urandom_range(9, 0));
      if (k == 0) wr("R10", 0, $urandom & 32'h0000_000E);
      else if (k == 1) wr("R12", 1, $urandom);
      else op("R8", 1'($urandom), 1'($urandom), 1'($urandom), k < 4);
    end
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule